// File: doc/BRIEF.md
# EPROM Bus Mode Decoder with Identifier

This block is a synchronous, device-side model of a word-wide programmable read-only memory as seen from its pins. Each clock it samples the chip select, output enable and program strobe (all active low) together with two boolean flags that stand in for analog levels. One flag says the programming supply is present. The other says the A9 address line is driven to its elevated identification level. From these it decodes a single operating mode: standby, program inhibit, output off, program, program verify, identifier, or read.

The storage is a register array of `1 << ADDR_W` words of `DATA_W` bits. Reset fills every bit with one, and a program cycle can only turn ones into zeros. Read data leaves on `dataOut`. `dataOe` stands for the pins being driven, and the data is meaningful only while `dataOe` is high. Access and float delays are counted in clock edges, set by `ACC_CYC`, `OE_CYC` and `DF_CYC`. A programmer can fetch two identifier bytes by selecting identifier mode and toggling address bit 0.

Top module: `prom_if_top`

## Requirements
- R1: While reset is asserted, and after it is released, `dataOe` is 0. Every array word reads 16'hFFFF until it is programmed.
- R2: With `ceN`=0, `oeN`=0, no program strobe and `a9High`=0, the block enters read mode and drives the word at `addr`. `dataOe` first goes high after the rising edge at which the address has been stable for `ACC_CYC` edges (the edge that first sees it counts as 1) and the enable pair has been low for `OE_CYC` edges. Before that edge `dataOe` is 0.
- R3: Raising `oeN` turns the outputs off whatever the other inputs are. `dataOe` is 0 from the `DF_CYC`-th edge that samples `oeN`=1.
- R4: Raising `ceN` puts the block in standby, even while `oeN` is low. `dataOe` is 0 from the `DF_CYC`-th edge that samples `ceN`=1.
- R5: With `vppOn`=1, `ceN`=0 and `pgmN`=0, each rising edge stores `old AND dataIn` at `addr`, so bits only ever clear. This mode takes priority over identifier and output enable, and it never drives the outputs.
- R6: With `ceN`=1, `vppOn`=1 and `pgmN`=0 (program inhibit), nothing is written and the outputs float.
- R7: With `vppOn`=1, `pgmN`=1, `ceN`=0 and `oeN`=0 (program verify), the block drives the stored word, with the same timing as R2.
- R8: With `a9High`=1, `ceN`=0, `oeN`=0 and no program strobe, the block returns an identifier. `addr[0]`=0 gives 16'h0001 (manufacturer) and `addr[0]`=1 gives 16'h008C (device). The upper byte is zero and all other address bits are ignored.
- R9: Every identifier word has an odd number of ones in bits 7:0, and bit 7 is the parity bit.
- R10: While the outputs are floating out, `dataOe` and `dataOut` hold their last values for `DF_CYC`-1 edges.
- R11: A change of `addr` or of `a9High` during a read drops `dataOe` at the first edge that sees it. Data returns `ACC_CYC` edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| a9High | input | 1 | A9 at identification level |
| vppOn | input | 1 | Programming supply present |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Data to program |
| dataOut | output | DATA_W | Read data |
| dataOe | output | 1 | Outputs driven with valid data |

## Verification
Most internal faults show up at the ports within a few edges.
- A wrong run counter either raises `dataOe` one edge early or late around the `ACC_CYC`/`OE_CYC` boundary, or keeps it high past the `DF_CYC`-th float edge.
- A wrong mode decode can show up as writes during inhibit or standby. These become visible only at the next read of that address.
- It can also show up as identifier bytes with the wrong parity or a nonzero upper byte, visible on the first valid identifier read.
- A program path that can set bits is caught when a second program pass with different data is read back.

// File: rtl/prom_if_pkg.sv
package prom_if_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_OFF,
    MD_PROGRAM,
    MD_VERIFY,
    MD_IDENT,
    MD_READ
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // clear bits at addr with dataIn
    logic capture;  // load output word, drive pins
    logic drop;     // stop driving pins
    logic idSel;    // output word comes from identifier table
  } strobe_t;

  localparam logic [6:0] MFG_ID7 = 7'h01;
  localparam logic [6:0] DEV_ID7 = 7'h0C;

  // bit 7 chosen so the byte holds an odd count of ones
  function automatic logic [7:0] withOddParity(input logic [6:0] v);
    return {~^v, v};
  endfunction

endpackage

// File: rtl/prom_if_ctrl.sv
module prom_if_ctrl
  import prom_if_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int OE_CYC  = 2,
  parameter int DF_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              a9High,
  input  logic              vppOn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);

  localparam int MAX_AO = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int MAXC   = (MAX_AO > DF_CYC) ? MAX_AO : DF_CYC;
  localparam int CW     = $clog2(MAXC + 2);

  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t CAP   = '1;
  localparam cnt_t ACC_L = cnt_t'(ACC_CYC);
  localparam cnt_t OE_L  = cnt_t'(OE_CYC);
  localparam cnt_t DF_L  = cnt_t'(DF_CYC);

  function automatic cnt_t bump(input cnt_t v);
    return (v == CAP) ? CAP : v + cnt_t'(1);
  endfunction

  mode_e             mode;
  logic [ADDR_W-1:0] lastAddr;
  logic              lastA9;
  cnt_t              addrRun, driveRun, offRun;
  cnt_t              addrRunNxt, driveRunNxt, offRunNxt;
  logic              drive, addrChg, dataValid;

  always_comb begin
    if (ceN)                 mode = vppOn ? MD_INHIBIT : MD_STANDBY;
    else if (vppOn && !pgmN) mode = MD_PROGRAM;
    else if (oeN)            mode = MD_OFF;
    else if (a9High)         mode = MD_IDENT;
    else if (vppOn)          mode = MD_VERIFY;
    else                     mode = MD_READ;
  end

  always_comb begin
    drive       = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
    addrChg     = (addr != lastAddr) || (a9High != lastA9);
    addrRunNxt  = addrChg ? cnt_t'(1) : bump(addrRun);
    driveRunNxt = drive ? bump(driveRun) : '0;
    offRunNxt   = drive ? '0 : bump(offRun);
    dataValid   = drive && (addrRunNxt >= ACC_L) && (driveRunNxt >= OE_L);

    stb.wrEn    = (mode == MD_PROGRAM);
    stb.idSel   = (mode == MD_IDENT);
    stb.capture = dataValid;
    stb.drop    = drive ? !dataValid : (offRunNxt >= DF_L);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastA9   <= 1'b0;
      addrRun  <= '0;
      driveRun <= '0;
      offRun   <= '0;
    end else begin
      lastAddr <= addr;
      lastA9   <= a9High;
      addrRun  <= addrRunNxt;
      driveRun <= driveRunNxt;
      offRun   <= offRunNxt;
    end
  end

endmodule

// File: rtl/prom_if_dp.sv
module prom_if_dp
  import prom_if_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] MFG_CODE = withOddParity(MFG_ID7);
  localparam logic [7:0] DEV_CODE = withOddParity(DEV_ID7);

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] idWord, rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
    end else if (stb.wrEn) begin
      memArr[addr] <= memArr[addr] & dataIn;
    end
  end

  always_comb begin
    idWord = '0;
    idWord[7:0] = addr[0] ? DEV_CODE : MFG_CODE;
    rdWord = stb.idSel ? idWord : memArr[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else if (stb.capture) begin
      dataOut <= rdWord;
      dataOe  <= 1'b1;
    end else if (stb.drop) begin
      dataOe  <= 1'b0;
    end
  end

endmodule

// File: rtl/prom_if_top.sv
module prom_if_top
  import prom_if_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int ACC_CYC = 3,
  parameter int OE_CYC  = 2,
  parameter int DF_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              a9High,
  input  logic              vppOn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  strobe_t stb;

  prom_if_ctrl #(
    .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .DF_CYC(DF_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .a9High(a9High), .vppOn(vppOn), .addr(addr), .stb(stb)
  );

  prom_if_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/prom_if_chk.sv
module prom_if_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int ACC_CYC = 3,
  parameter int OE_CYC  = 2,
  parameter int DF_CYC  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              pgmN,
  input logic              a9High,
  input logic              vppOn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);

  localparam int CW = $clog2(ACC_CYC + OE_CYC + DF_CYC + 2);
  typedef logic [CW-1:0] ck_t;
  localparam ck_t TOP = '1;

  logic              ckDrive;
  logic [ADDR_W-1:0] ckAddr;
  logic              ckA9, idEdge;
  ck_t               ckAddrRun, ckDriveRun, ckOffRun;

  assign ckDrive = !ceN && !oeN && !(vppOn && !pgmN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckAddr     <= '0;
      ckA9       <= 1'b0;
      ckAddrRun  <= '0;
      ckDriveRun <= '0;
      ckOffRun   <= '0;
      idEdge     <= 1'b0;
    end else begin
      ckAddr     <= addr;
      ckA9       <= a9High;
      ckAddrRun  <= ((addr != ckAddr) || (a9High != ckA9)) ? ck_t'(1)
                  : (ckAddrRun == TOP ? TOP : ckAddrRun + ck_t'(1));
      ckDriveRun <= !ckDrive ? '0 : (ckDriveRun == TOP ? TOP : ckDriveRun + ck_t'(1));
      ckOffRun   <= ckDrive ? '0 : (ckOffRun == TOP ? TOP : ckOffRun + ck_t'(1));
      idEdge     <= ckDrive && a9High;
    end
  end

  AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && ckDriveRun != '0) |-> (ckAddrRun >= ck_t'(ACC_CYC) && ckDriveRun >= ck_t'(OE_CYC))); // R2 R11

  AST_FLOAT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (ckOffRun >= ck_t'(DF_CYC)) |-> !dataOe); // R3 R10

  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(!ceN && !oeN)); // R4

  AST_PROG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> !$past(vppOn && !pgmN)); // R5

  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (idEdge && dataOe) |-> (dataOut[DATA_W-1:8] == '0 && ($countones(dataOut[7:0]) % 2) == 1)); // R9

endmodule

bind prom_if_top prom_if_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .DF_CYC(DF_CYC)
) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .a9High(a9High),
  .vppOn(vppOn), .addr(addr), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/prom_if_top_tb_top.sv
module prom_if_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, pgmN = 1'b1, a9High = 1'b0, vppOn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic              oe;
    logic [DATA_W-1:0] data;
    bit                par;
    string             tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_if_top dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .a9High(a9High),
    .vppOn(vppOn), .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pushExp(input logic oe, input logic [DATA_W-1:0] d, input bit par, input string tag);
    exp_t e;
    e.oe = oe; e.data = d; e.par = par; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: compares one expected item per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (dataOe !== e.oe) begin
          errors++;
          $display("FAIL %s: dataOe actual=%b expected=%b", e.tag, dataOe, e.oe);
        end else if (e.oe && dataOut !== e.data) begin
          errors++;
          $display("FAIL %s: dataOut actual=%h expected=%h", e.tag, dataOut, e.data);
        end
        if (e.par) begin
          checks++;
          if ((^dataOut[7:0]) !== 1'b1) begin
            errors++;
            $display("FAIL R9 parity: actual=%b expected=1", ^dataOut[7:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    // reset
    step(2);
    pushExp(1'b0, '0, 0, "R1 in reset");
    step(1);
    rstN = 1'b1;
    step(1);
    pushExp(1'b0, '0, 0, "R1 after reset");

    // erased read with access delay boundary
    ceN = 0; oeN = 0; addr = 8'd5;
    step(2); pushExp(1'b0, '0, 0, "R2 before access time");
    step(1); pushExp(1'b1, 16'hFFFF, 0, "R1 erased word");

    // output enable release with float delay
    oeN = 1;
    step(1); pushExp(1'b1, 16'hFFFF, 0, "R10 hold during float");
    step(1); pushExp(1'b0, '0, 0, "R3 floated after oeN high");

    // program two passes at 5, one at 6
    vppOn = 1; pgmN = 0; dataIn = 16'hA5F0;
    step(1); pushExp(1'b0, '0, 0, "R5 no drive in program");
    dataIn = 16'hFF0F;
    step(1);
    addr = 8'd6; dataIn = 16'h1234;
    step(1);

    // verify
    pgmN = 1; oeN = 0; addr = 8'd5;
    step(2); pushExp(1'b0, '0, 0, "R7 before access time");
    step(1); pushExp(1'b1, 16'hA500, 0, "R7 verify cleared-only word");

    // inhibit
    ceN = 1; oeN = 1; pgmN = 0; addr = 8'd7; dataIn = 16'h0000;
    step(1); pushExp(1'b1, 16'hA500, 0, "R10 hold during float");
    step(1); pushExp(1'b0, '0, 0, "R6 inhibit floats");
    step(1);
    vppOn = 0; pgmN = 1; ceN = 0; oeN = 0;
    step(1); pushExp(1'b0, '0, 0, "R2 output enable delay");
    step(1); pushExp(1'b1, 16'hFFFF, 0, "R6 inhibit did not write");

    // standby while oeN low
    ceN = 1;
    step(1); pushExp(1'b1, 16'hFFFF, 0, "R10 hold after ceN high");
    step(1); pushExp(1'b0, '0, 0, "R4 standby floats");
    step(2); pushExp(1'b0, '0, 0, "R4 standby stays floated");

    // read programmed word
    ceN = 0; addr = 8'd6;
    step(3); pushExp(1'b1, 16'h1234, 0, "R2 read programmed word");

    // address change during read
    addr = 8'd5;
    step(1); pushExp(1'b0, '0, 0, "R11 drop on address change");
    step(1); pushExp(1'b0, '0, 0, "R11 still waiting");
    step(1); pushExp(1'b1, 16'hA500, 0, "R11 new word valid");

    // identifier
    a9High = 1; addr = 8'd0;
    step(2); pushExp(1'b0, '0, 0, "R11 a9 change restarts access");
    step(1); pushExp(1'b1, 16'h0001, 1, "R8 manufacturer code");
    addr = 8'd1;
    step(3); pushExp(1'b1, 16'h008C, 1, "R8 device code");
    addr = 8'h81;
    step(3); pushExp(1'b1, 16'h008C, 1, "R8 upper address bits ignored");

    // program takes priority over identifier
    vppOn = 1; pgmN = 0; dataIn = 16'h0F0F;
    step(1); pushExp(1'b1, 16'h008C, 0, "R10 hold entering program");
    step(1); pushExp(1'b0, '0, 0, "R5 program over identifier, no drive");
    vppOn = 0; pgmN = 1; a9High = 0;
    step(2); pushExp(1'b0, '0, 0, "R11 a9 drop restarts access");
    step(1); pushExp(1'b1, 16'h0F0F, 0, "R5 word written under identifier select");

    // output enable late after a stable address
    oeN = 1; addr = 8'h20;
    step(5); pushExp(1'b0, '0, 0, "R3 off while oeN high");
    oeN = 0;
    step(1); pushExp(1'b0, '0, 0, "R2 one edge after oeN low");
    step(1); pushExp(1'b1, 16'hFFFF, 0, "R2 valid after output enable delay");

    step(2);
    summary();
  end

endmodule